// File: doc/BRIEF.md
# Data-Driven Burst Clock Controller

This block wakes a consumer clock only when a new data word shows up. When the producer strobes a word in, the controller takes a cycle count k from that word, captures the word into a holding register and enables the consumer clock for exactly k cycles. After the last enabled cycle it stops the clock, pulses a completion flag and goes back to waiting. A word whose count is zero is acknowledged at once and produces no clock pulse.

The consumer sees two things: a registered clock-enable and a gated clock. The gated clock comes from a latch-based gate that only takes a new enable while the source clock is low, so every pulse it produces is full width. The captured word stays put for the whole burst, so the consumer can read it without a synchronizer. The consumer is not pipelined, so the controller accepts a new word only while it is idle.

The controller is a two-state machine. In **IDLE** the ready output is high and a valid strobe is accepted. The transition *IDLE→RUN* happens on a strobe whose count is non-zero. The transition *IDLE→IDLE (zero burst)* happens on a strobe whose count is zero and raises done. In **RUN** the enable is high and the counter steps down by one each cycle. *RUN→RUN* repeats while more than one cycle is left. *RUN→IDLE* happens on the last enabled cycle and raises done. The count comes either from a bit field of the word (the default) or from the number of ones in the word, chosen by a parameter.

Top module: `burst_clk_ctrl`

## Requirements
- R1: After reset, ready=1, busy=0, done=0, clk_en=0 and gclk stays low.
- R2: In field mode (MAP_MODE=0, default) the burst length is k = in_data[K_LSB +: K_W]. The defaults are K_LSB=0 and K_W=4, so k is bits 3:0 of the 8-bit word.
- R3: A word is accepted on a rising clk edge where in_valid=1 and ready=1. In the cycle that follows, for k>0, busy=1, ready=0 and clk_en=1.
- R4: For each accepted word, gclk makes exactly k rising edges and clk_en is high for exactly k cycles.
- R5: done is high for the one cycle after the last enabled cycle. In that same cycle ready=1 and busy=0.
- R6: A word with k=0 makes no gclk edge. done=1 in the cycle after acceptance, and ready stays 1.
- R7: hold_data takes in_data at acceptance and keeps that value until the next acceptance.
- R8: in_valid while busy=1 has no effect: the burst length, the done timing and hold_data are unchanged.
- R9: gclk is never high while clk is low, and its enable changes only while clk is low.
- R10: A new word presented in the cycle where done=1 is accepted at once, so bursts can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer strobe: new word present |
| in_data | input | DATA_W | Producer data word |
| ready | output | 1 | High only in IDLE, so a word can be accepted |
| busy | output | 1 | High while a burst runs |
| done | output | 1 | One-cycle pulse when a burst (or a zero burst) ends |
| clk_en | output | 1 | Registered consumer clock enable |
| gclk | output | 1 | Glitch-free gated consumer clock |
| hold_data | output | DATA_W | Word captured at acceptance, stable during the burst |

## Verification
Let edge E0 be the one that accepts a word. busy, ready and clk_en change just after E0, and gclk pulses on edges E1 through Ek. done appears just after Ek, or just after E0 when k=0. The bench drives inputs at falling edges and samples at falling edges. It counts the falling edges that pass after acceptance until done appears and expects that count to equal k. In parallel it counts rising edges of gclk and expects that count to equal k as well. To test R8, a strobe carrying a different word is injected in the middle of a burst, and the bench confirms that hold_data and both counts are unchanged.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } burst_state_t;

    localparam int MAP_FIELD    = 0;
    localparam int MAP_POPCOUNT = 1;
endpackage

// File: rtl/burst_len_map.sv
module burst_len_map #(
    parameter int DATA_W   = 8,
    parameter int K_LSB    = 0,
    parameter int K_W      = 4,
    parameter int MAP_MODE = 0,
    parameter int CNT_W    = 4
) (
    input  logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  k
);
    generate
        if (MAP_MODE == burst_pkg::MAP_POPCOUNT) begin : g_pop
            always_comb begin
                k = '0;
                for (int i = 0; i < DATA_W; i++) begin
                    k = k + CNT_W'(data[i]);
                end
            end
        end else begin : g_field
            always_comb begin
                k = CNT_W'(data[K_LSB +: K_W]);
            end
        end
    endgenerate
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic k_zero,
    input  logic last,
    output logic accept,
    output logic ready,
    output logic busy,
    output logic run_en,
    output logic done
);
    import burst_pkg::*;

    burst_state_t state_q, state_d;

    assign accept = in_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !k_zero) state_d = ST_RUN;
            ST_RUN:  if (last)              state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: done <= accept && k_zero;
                ST_RUN:  done <= last;
                default: done <= 1'b0;
            endcase
        end
    end

    assign ready  = (state_q == ST_IDLE);
    assign busy   = (state_q == ST_RUN);
    assign run_en = busy;
endmodule

// File: rtl/clk_gate.sv
module clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    always_latch begin
        if (!clk) en_lat = en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/burst_clk_ctrl.sv
module burst_clk_ctrl #(
    parameter int DATA_W   = 8,
    parameter int K_LSB    = 0,
    parameter int K_W      = 4,
    parameter int MAP_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              ready,
    output logic              busy,
    output logic              done,
    output logic              clk_en,
    output logic              gclk,
    output logic [DATA_W-1:0] hold_data
);
    localparam int CNT_W = (MAP_MODE == burst_pkg::MAP_POPCOUNT) ? $clog2(DATA_W + 1) : K_W;

    logic [CNT_W-1:0] k_val;
    logic             k_zero;
    logic             last;
    logic             accept;

    burst_len_map #(
        .DATA_W(DATA_W), .K_LSB(K_LSB), .K_W(K_W),
        .MAP_MODE(MAP_MODE), .CNT_W(CNT_W)
    ) i_map (
        .data(in_data),
        .k(k_val)
    );

    assign k_zero = (k_val == '0);

    burst_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .k_zero(k_zero), .last(last), .accept(accept),
        .ready(ready), .busy(busy), .run_en(clk_en), .done(done)
    );

    burst_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .load_val(k_val), .step(clk_en), .last(last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_data <= '0;
        else if (accept) hold_data <= in_data;
    end

    clk_gate i_gate (.clk(clk), .en(clk_en), .gclk(gclk));
endmodule

// File: rtl/burst_clk_ctrl_chk.sv
module burst_clk_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              ready,
    input logic              busy,
    input logic              done,
    input logic              clk_en,
    input logic              gclk,
    input logic [DATA_W-1:0] hold_data
);
    // R3: ready and busy are never high together
    a_r3_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && busy));

    // R3: a burst starts only from an accepted strobe
    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready && !done) |=> (busy || done));

    // R5: the end of a burst comes with done
    a_r5_end_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R5: done only in idle
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    // R4: the enable follows the running state
    a_r4_en_busy: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> busy);

    // R7/R8: the held word does not move during a burst
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(hold_data));

    // R9: no gated pulse while the source clock is low
    always_comb begin
        a_r9_no_glitch: assert (!(gclk && !clk));
    end
endmodule

bind burst_clk_ctrl burst_clk_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ready(ready),
    .busy(busy), .done(done), .clk_en(clk_en), .gclk(gclk),
    .hold_data(hold_data)
);

// File: tb/test_burst_clk_ctrl.sv
module test_burst_clk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       ready, busy, done, clk_en, gclk;
    logic [7:0] hold_data;

    int total = 0;
    int bad = 0;
    int gedges = 0;
    bit finished = 1'b0;

    localparam int NVEC = 8;
    localparam logic [7:0] VEC [NVEC] = '{8'h01, 8'h52, 8'hA7, 8'h3F, 8'hC4, 8'h18, 8'h6B, 8'hF3};

    always #5 clk = ~clk;

    always @(posedge gclk) gedges++;

    burst_clk_ctrl i_burst_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .ready(ready), .busy(busy), .done(done), .clk_en(clk_en),
        .gclk(gclk), .hold_data(hold_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present a word, count cycles to done and gated edges; optionally inject a strobe mid-burst
    task automatic run_word(input logic [7:0] w, input bit inject);
        int k = int'(w[3:0]);   // R2: k is bits 3:0
        int n = 0;
        int en_cycles = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        gedges   = 0;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'h00;
        check(hold_data == w, "R7 capture", int'(hold_data), int'(w));
        if (k == 0) begin
            check(done == 1'b1, "R6 done", int'(done), 1);
            check(ready == 1'b1, "R6 ready", int'(ready), 1);
            @(negedge clk);
            check(gedges == 0, "R6 edges", gedges, 0);
            return;
        end
        check(busy && !ready && clk_en, "R3 start", int'({busy, ready, clk_en}), 5);
        while (!done && n < 40) begin
            if (clk_en) en_cycles++;
            if (inject && n == 1) begin
                in_valid = 1'b1;
                in_data  = ~w;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        in_valid = 1'b0;
        check(n == k, "R4 cycles", n, k);
        check(en_cycles == k, "R4 enable", en_cycles, k);
        check(gedges == k, "R4 gclk edges", gedges, k);
        check(ready && !busy, "R5 idle at done", int'({ready, busy}), 2);
        if (inject) check(hold_data == w, "R8 hold", int'(hold_data), int'(w));
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(ready == 1'b1 && busy == 1'b0 && done == 1'b0 && clk_en == 1'b0 && gclk == 1'b0,
              "R1 reset", int'({ready, busy, done, clk_en, gclk}), 16);
        rst_n = 1'b1;
        @(negedge clk);
        check(gedges == 0, "R1 no edges", gedges, 0);

        for (int i = 0; i < NVEC; i++) run_word(VEC[i], 1'b0);

        run_word(8'hE0, 1'b0);              // R6 zero burst
        run_word(8'h0F, 1'b0);              // R4 max length
        run_word(8'h29, 1'b1);              // R8 strobe ignored mid-burst

        // R10 back to back: present next word in the done cycle
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h02; gedges = 0;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R5 done wait", int'(done), 0);
        @(negedge clk);
        check(done == 1'b1, "R10 first done", int'(done), 1);
        in_valid = 1'b1; in_data = 8'h03;
        @(negedge clk);
        in_valid = 1'b0;
        check(busy && hold_data == 8'h03, "R10 accepted", int'(hold_data), 3);
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R10 second done", int'(done), 1);
        check(gedges == 5, "R10 edges", gedges, 5);
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", int'(done), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule